// File: doc/BRIEF.md
# Self-Timed Nonvolatile Program Sequencer

This block runs the programming cycles of a small word-organized nonvolatile memory model. A serial front end decodes each instruction and passes it in as a one-cycle command strobe with an operation code, a word address and a data word. The sequencer keeps a program-enable latch and accepts erase and write commands only while the latch is set. An accepted program command is held until chip select falls, and only then does the self-timed cycle begin. During the cycle the block drives the memory array write port and measures the cycle length in ticks of a prescaled system clock.

Word erase writes all ones to one word. Erase-all writes all ones to every word in ascending order. A word write first erases its word and then programs the data. Write-all first sweeps all ones across the array and then sweeps the data across it. Status appears on a tristate-style data-out pair (`do_oe`, `do_val`) when chip select rises again after a long enough deselect. The rest of the chip sees `busy` and a one-clock `done` pulse.

The controller has six states. `S_IDLE` goes to `S_ARMED` when it loads an enabled program command. `S_ARMED` goes to `S_ERASE` on a chip-select fall. `S_ERASE` goes to `S_PROG` (write kinds) or `S_WAIT` (erase kinds) after its last erase write. `S_PROG` goes to `S_WAIT` after its last data write. `S_WAIT` goes to `S_DONE` once the tick count reaches the limit. `S_DONE` returns to `S_IDLE` after one clock.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_we` and `do_oe` are 0 and the enable latch is clear. Program commands (codes 1 erase, 2 erase-all, 3 write, 4 write-all) are not executed until an enable command (code 5) has been accepted.
- R2: The enable latch stays set across any number of cycles until a disable command (code 6) clears it. A read command (code 0) neither sets nor clears the latch.
- R3: An accepted program command does not start a cycle until chip select is sampled low after being sampled high. `busy` rises one clock after that sample, and never before it.
- R4: Word erase writes all ones once, at the command address. Erase-all writes all ones to addresses 0 to DEPTH-1 in ascending order.
- R5: A word write produces two writes to its address: all ones first, then the data. Write-all produces DEPTH all-ones writes in ascending order, then DEPTH data writes in ascending order.
- R6: `busy` stays high for exactly T_WORD*PRESCALE+1 clocks for codes 1 to 3, and T_ALL*PRESCALE+1 clocks for code 4.
- R7: Neither chip select changes nor commands received during a running cycle abort it, restart it or queue another cycle.
- R8: When chip select rises after at least MIN_CSL clocks low, and a cycle has started or a command has been refused since the last accepted load, `do_oe` is 1 from the next clock and `do_val` is the inverse of `busy`. A shorter deselect leaves `do_oe` at 0.
- R9: `do_oe` is 0 from the clock after chip select is sampled low. It stays 0 for a whole cycle run with chip select held low.
- R10: A program command refused because the latch is clear causes no busy period and no array write. The next qualified chip-select rise shows ready (`do_val` = 1).
- R11: At the end of a cycle `done` is high for exactly one clock, in the same clock that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, synchronous to clk |
| cmd_valid | input | 1 | One-clock strobe for a decoded command |
| cmd_op | input | 3 | Operation code (0 read, 1 erase, 2 erase-all, 3 write, 4 write-all, 5 enable, 6 disable) |
| cmd_addr | input | $clog2(DEPTH) | Word address of the command |
| cmd_data | input | WIDTH | Data word for writes |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | $clog2(DEPTH) | Array write address |
| mem_wdata | output | WIDTH | Array write data |
| busy | output | 1 | A program cycle is running |
| done | output | 1 | One-clock end-of-cycle pulse |
| do_oe | output | 1 | Status output drive enable |
| do_val | output | 1 | Status value, 1 ready, 0 busy |

## Verification
The main function is swept with a word write at every address, using a data value computed from the address. This shows that the erase write comes before the data write and that each pair lands on its own address. Each of the four program codes is also sent with the latch clear, which shows refusal apart from a slow start. Write-all is then polled with chip select raised in the middle of the cycle, with a deselect that is too short and with a command received while busy. These show busy status apart from ready status and show that a running cycle ignores outside events. Erase, erase-all and a disable followed by a write finish the set, and each busy length is compared with the tick arithmetic.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_ERASE     = 3'd1,
        OP_ERASE_ALL = 3'd2,
        OP_WRITE     = 3'd3,
        OP_WRITE_ALL = 3'd4,
        OP_PGM_ON    = 3'd5,
        OP_PGM_OFF   = 3'd6,
        OP_NONE      = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_ERASE,
        S_PROG,
        S_WAIT,
        S_DONE
    } state_e;

    function automatic logic is_program(op_e op);
        return (op == OP_ERASE) || (op == OP_ERASE_ALL) ||
               (op == OP_WRITE) || (op == OP_WRITE_ALL);
    endfunction

    function automatic logic is_sweep(op_e op);
        return (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
    endfunction

    function automatic logic has_data(op_e op);
        return (op == OP_WRITE) || (op == OP_WRITE_ALL);
    endfunction

endpackage

// File: rtl/nvm_wen_latch.sv
module nvm_wen_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wen_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_o <= 1'b0;
        end else if (clr_i) begin
            wen_o <= 1'b0;
        end else if (set_i) begin
            wen_o <= 1'b1;
        end
    end

    // R2
    wen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_o && !clr_i) |=> wen_o);

endmodule

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
    parameter int PRESCALE = 125,
    parameter int TW       = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);

    logic          tick;
    logic [TW-1:0] tcnt;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcnt <= '0;
                end else if (start_i) begin
                    pcnt <= '0;
                end else if (run_i) begin
                    if (pcnt == PLAST) begin
                        pcnt <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
            end

            assign tick = run_i && !start_i && (pcnt == PLAST);
        end else begin : g_nodiv
            assign tick = run_i && !start_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (start_i) begin
            tcnt <= '0;
        end else if (tick && (tcnt != '1)) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign expired_o = (tcnt >= limit_i);

    // R6
    expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && run_i && !start_i && $stable(limit_i)) |=> expired_o);

endmodule

// File: rtl/nvm_status_out.sv
module nvm_status_out #(
    parameter int MIN_CSL = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic busy_i,
    input  logic avail_set_i,
    input  logic avail_clr_i,
    output logic do_oe_o,
    output logic do_val_o
);

    localparam int CW = $clog2(MIN_CSL + 1);
    localparam logic [CW-1:0] CMIN = CW'(MIN_CSL);

    logic          cs_q;
    logic [CW-1:0] lowcnt;
    logic          avail_q;
    logic          oe_q;
    logic          cs_rise;

    assign cs_rise = cs_i && !cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            lowcnt <= '0;
        end else begin
            cs_q <= cs_i;
            if (!cs_i) begin
                if (lowcnt != CMIN) begin
                    lowcnt <= lowcnt + 1'b1;
                end
            end else begin
                lowcnt <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avail_q <= 1'b0;
        end else if (avail_set_i) begin
            avail_q <= 1'b1;
        end else if (avail_clr_i) begin
            avail_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (!cs_i) begin
            oe_q <= 1'b0;
        end else if (cs_rise && (lowcnt >= CMIN) && avail_q) begin
            oe_q <= 1'b1;
        end
    end

    assign do_oe_o  = oe_q;
    assign do_val_o = !busy_i;

    // R9
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !do_oe_o);

    // R8
    oe_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe_o) |-> ($past(avail_q) && $past(cs_i)));

endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
    import nvm_seq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int WIDTH    = 16,
    parameter int PRESCALE = 125,
    parameter int T_WORD   = 6000,
    parameter int T_ALL    = 15000,
    parameter int MIN_CSL  = 32,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [WIDTH-1:0] cmd_data,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    output logic             busy,
    output logic             done,
    output logic             do_oe,
    output logic             do_val
);

    localparam int TMAX = (T_ALL > T_WORD) ? T_ALL : T_WORD;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [TW-1:0] LIM_WORD  = TW'(T_WORD);
    localparam logic [TW-1:0] LIM_ALL   = TW'(T_ALL);

    state_e           state, state_nx;
    op_e              op_in, op_r;
    logic [AW-1:0]    addr_r, sweep_addr;
    logic [WIDTH-1:0] data_r;
    logic             cs_q;
    logic             wen;
    logic             tmr_expired;
    logic [TW-1:0]    limit;

    logic cmd_pgm, load, reject, cs_fall, start;
    logic pgm_on, pgm_off;
    logic all_op, data_op, sweep_last, sweep_step;

    assign op_in = op_e'(cmd_op);

    always_comb begin
        cmd_pgm    = cmd_valid && is_program(op_in);
        load       = (state == S_IDLE) && cmd_pgm && wen;
        reject     = (state == S_IDLE) && cmd_pgm && !wen;
        pgm_on     = cmd_valid && (op_in == OP_PGM_ON);
        pgm_off    = cmd_valid && (op_in == OP_PGM_OFF);
        cs_fall    = cs_q && !cs;
        start      = (state == S_ARMED) && cs_fall;
        all_op     = is_sweep(op_r);
        data_op    = has_data(op_r);
        sweep_last = !all_op || (sweep_addr == LAST_ADDR);
        sweep_step = (state == S_ERASE) || (state == S_PROG);
        limit      = (op_r == OP_WRITE_ALL) ? LIM_ALL : LIM_WORD;
    end

    nvm_wen_latch u_wen (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (pgm_on),
        .clr_i (pgm_off),
        .wen_o (wen)
    );

    nvm_cycle_timer #(
        .PRESCALE (PRESCALE),
        .TW       (TW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .run_i     (busy),
        .limit_i   (limit),
        .expired_o (tmr_expired)
    );

    nvm_status_out #(
        .MIN_CSL (MIN_CSL)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs),
        .busy_i      (busy),
        .avail_set_i (start || reject),
        .avail_clr_i (load),
        .do_oe_o     (do_oe),
        .do_val_o    (do_val)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (load) state_nx = S_ARMED;
            S_ARMED: if (cs_fall) state_nx = S_ERASE;
            S_ERASE: if (sweep_last) state_nx = data_op ? S_PROG : S_WAIT;
            S_PROG:  if (sweep_last) state_nx = S_WAIT;
            S_WAIT:  if (tmr_expired) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cs_q  <= 1'b0;
        end else begin
            state <= state_nx;
            cs_q  <= cs;
        end
    end

    // command hold and sweep address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r       <= OP_NONE;
            addr_r     <= '0;
            data_r     <= '0;
            sweep_addr <= '0;
        end else begin
            if (load) begin
                op_r   <= op_in;
                addr_r <= cmd_addr;
                data_r <= cmd_data;
            end
            if (sweep_step) begin
                if (sweep_last) begin
                    sweep_addr <= '0;
                end else begin
                    sweep_addr <= sweep_addr + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = all_op ? sweep_addr : addr_r;
        mem_wdata = data_r;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_IDLE, S_ARMED: ;
            S_ERASE: begin
                mem_we    = 1'b1;
                mem_wdata = '1;
                busy      = 1'b1;
            end
            S_PROG: begin
                mem_we = 1'b1;
                busy   = 1'b1;
            end
            S_WAIT:  busy = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    // R1
    arm_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && $past(state) == S_IDLE) |-> $past(wen));

    // R3
    start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_q) && !$past(cs)));

    // R5
    erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG && $past(state) != S_PROG) |-> ($past(state) == S_ERASE));

    // R7
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_expired) |=> busy);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: tb/nvm_prog_seq_test.sv
`timescale 1ns/1ps
module nvm_prog_seq_test;

    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int PRE   = 4;
    localparam int TWD   = 10;
    localparam int TAL   = 20;
    localparam int MCSL  = 3;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [AW-1:0]    cmd_addr = '0;
    logic [WIDTH-1:0] cmd_data = '0;
    logic             mem_we, busy, done, do_oe, do_val;
    logic [AW-1:0]    mem_addr;
    logic [WIDTH-1:0] mem_wdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0]    log_a [0:63];
    logic [WIDTH-1:0] log_d [0:63];
    int               log_n = 0;

    always #4 clk = ~clk;

    nvm_prog_seq #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .PRESCALE(PRE),
        .T_WORD(TWD), .T_ALL(TAL), .MIN_CSL(MCSL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .do_oe(do_oe), .do_val(do_val)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            log_a[log_n % 64] <= mem_addr;
            log_d[log_n % 64] <= mem_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input int op, input int a, input int d);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_addr  = AW'(a);
        cmd_data  = WIDTH'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_cs(input int lowclk);
        cs = 1'b0;
        repeat (lowclk) @(negedge clk);
        cs = 1'b1;
        @(negedge clk);
    endtask

    function automatic int exp_len(input int op);
        return ((op == 4) ? TAL : TWD) * PRE + 1;
    endfunction

    // runs one program cycle with cs low the whole time
    task automatic run_cycle(input int op, input int a, input int d,
                             output int bc, output int dc);
        int early;
        cs = 1'b1;
        repeat (2) @(negedge clk);
        send_cmd(op, a, d);
        early = 0;
        repeat (3) begin
            @(negedge clk);
            early += int'(busy);
        end
        chk(early == 0, "R3 no start before cs falls", early, 0);
        cs = 1'b0;
        bc = 0;
        dc = 0;
        for (int g = 0; g < 1000 && dc == 0; g++) begin
            @(negedge clk);
            bc += int'(busy);
            if (do_oe) begin
                chk(1'b0, "R9 do_oe with cs low", 1, 0);
            end
            if (done) begin
                dc++;
                chk(!busy, "R11 busy falls with done", int'(busy), 0);
            end
        end
        @(negedge clk);
        chk(!done, "R11 done one clock", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bc, dc, base, g, early;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !do_oe, "R1 reset outputs",
            int'({busy, done, mem_we, do_oe}), 0);

        // R10 / R1: every program code refused while latch clear
        for (int op = 1; op <= 4; op++) begin
            base = log_n;
            send_cmd(op, 3, 8'h11);
            cs = 1'b0;
            early = 0;
            repeat (5) begin
                @(negedge clk);
                early += int'(busy);
            end
            cs = 1'b1;
            @(negedge clk);
            chk(early == 0 && log_n == base, "R1 refused without enable", early + log_n - base, 0);
            chk(do_oe && do_val, "R10 ready status after refusal", int'({do_oe, do_val}), 3);
        end

        // R2: read does not set the latch
        send_cmd(0, 0, 0);
        base = log_n;
        send_cmd(3, 2, 8'h22);
        pulse_cs(5);
        repeat (3) @(negedge clk);
        chk(log_n == base && !busy, "R2 read leaves latch clear", log_n - base, 0);

        // enable, then read, latch stays set
        send_cmd(5, 0, 0);
        send_cmd(0, 0, 0);

        // R5 / R6: word write at every address
        for (int a = 0; a < DEPTH; a++) begin
            int d;
            d = (a * 13 + 7) & 8'hFF;
            base = log_n;
            run_cycle(3, a, d, bc, dc);
            chk(bc == exp_len(3), "R6 write busy length", bc, exp_len(3));
            chk(dc == 1, "R11 one done", dc, 1);
            chk(log_n - base == 2, "R5 two writes", log_n - base, 2);
            chk(log_a[base % 64] == AW'(a) && log_d[base % 64] == 8'hFF,
                "R5 erase step first", int'(log_d[base % 64]), 255);
            chk(log_a[(base + 1) % 64] == AW'(a) && log_d[(base + 1) % 64] == WIDTH'(d),
                "R5 data step", int'(log_d[(base + 1) % 64]), d);
        end

        // R4: word erase
        base = log_n;
        run_cycle(1, 9, 8'h00, bc, dc);
        chk(bc == exp_len(1), "R6 erase busy length", bc, exp_len(1));
        chk(log_n - base == 1 && log_a[base % 64] == 4'd9 && log_d[base % 64] == 8'hFF,
            "R4 word erase", log_n - base, 1);

        // R4: erase-all
        base = log_n;
        run_cycle(2, 0, 8'h00, bc, dc);
        chk(bc == exp_len(2), "R6 erase-all busy length", bc, exp_len(2));
        chk(log_n - base == DEPTH, "R4 erase-all count", log_n - base, DEPTH);
        g = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (log_a[(base + i) % 64] != AW'(i) || log_d[(base + i) % 64] != 8'hFF) g++;
        end
        chk(g == 0, "R4 erase-all order and value", g, 0);

        // R5 / R6 / R7 / R8: write-all with status polling
        cs = 1'b1;
        repeat (2) @(negedge clk);
        base = log_n;
        send_cmd(4, 0, 8'h5A);
        cs = 1'b0;
        bc = 0;
        dc = 0;
        repeat (5) begin
            @(negedge clk);
            bc += int'(busy);
        end
        cs = 1'b1;
        @(negedge clk);
        bc += int'(busy);
        chk(do_oe && !do_val, "R8 busy status mid-cycle", int'({do_oe, do_val}), 2);
        cmd_valid = 1'b1;
        cmd_op    = 3'd3;
        cmd_addr  = 4'd1;
        cmd_data  = 8'h77;
        @(negedge clk);
        bc += int'(busy);
        cmd_valid = 1'b0;
        cs = 1'b0;
        @(negedge clk);
        bc += int'(busy);
        cs = 1'b1;
        @(negedge clk);
        bc += int'(busy);
        chk(!do_oe, "R8 short deselect no status", int'(do_oe), 0);
        for (int k = 0; k < 1000 && dc == 0; k++) begin
            @(negedge clk);
            bc += int'(busy);
            if (done) dc++;
        end
        chk(bc == exp_len(4), "R6 write-all busy length", bc, exp_len(4));
        chk(dc == 1, "R7 cycle not restarted", dc, 1);
        chk(log_n - base == 2 * DEPTH, "R5 write-all count", log_n - base, 2 * DEPTH);
        g = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (log_a[(base + i) % 64] != AW'(i) || log_d[(base + i) % 64] != 8'hFF) g++;
            if (log_a[(base + DEPTH + i) % 64] != AW'(i) ||
                log_d[(base + DEPTH + i) % 64] != 8'h5A) g++;
        end
        chk(g == 0, "R5 write-all erase then fill order", g, 0);
        @(negedge clk);
        chk(!done, "R11 done one clock", int'(done), 0);
        pulse_cs(5);
        chk(do_oe && do_val, "R8 ready after finish", int'({do_oe, do_val}), 3);
        early = 0;
        cs = 1'b0;
        repeat (8) begin
            @(negedge clk);
            early += int'(busy);
        end
        cs = 1'b1;
        @(negedge clk);
        chk(early == 0 && log_n == base + 2 * DEPTH, "R7 command during busy dropped",
            early, 0);

        // R2: disable clears the latch
        send_cmd(6, 0, 0);
        base = log_n;
        send_cmd(3, 4, 8'h33);
        early = 0;
        cs = 1'b0;
        repeat (6) begin
            @(negedge clk);
            early += int'(busy);
        end
        cs = 1'b1;
        @(negedge clk);
        chk(early == 0 && log_n == base, "R2 disable blocks write", early, 0);
        chk(do_oe && do_val, "R10 refusal shows ready", int'({do_oe, do_val}), 3);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule